// File: doc/BRIEF.md
# Paged MDIO-to-32-bit Register Bridge

This block lets a station management master reach a wide 32-bit internal register space through ordinary 16-bit clause-22 management frames. The bridge listens on the shared management line as a slave. It decodes each frame and, when the frame belongs to it, turns the frame into a single-cycle 32-bit read or write strobe on a simple internal bus. The register file behind that bus is outside this block.

A word address is built from three places. A 9-bit page register, reached at PHY address 0x1F register 0x10, supplies the top bits. The low three bits of the PHY address, within the window 0x10 to 0x17, supply the middle bits. Bits 4:1 of the register number supply the bottom bits. Bit 0 of the register number chooses a 16-bit half of the 32-bit word: 0 selects the low half and 1 selects the high half.

Software writes the high half first. The bridge keeps that half in a staging register and commits the full word when the low half arrives. Software reads the low half first. That read performs the bus read and holds the upper half, so a following high-half read returns data taken at the same moment. The management clock is oversampled by the system clock, which must run several times faster.

Top module: `mdio_page_bridge`

## Requirements
- R1: After reset, mdioOe is 0, busRdEn and busWrEn are 0, and the page register reads back as 0.
- R2: A write frame to PHY 0x1F register 0x10 loads data bits 8:0 into the page register. A read frame at that location returns the page zero-extended to 16 bits.
- R3: The word address on busAddr is {page[8:0], phy[2:0], regnum[4:1]}. It is 16 bits wide, with bit 15 as the page MSB.
- R4: A write frame to an odd register number in the window (PHY 0x10 to 0x17) only stages its 16 data bits and produces no busWrEn.
- R5: A write frame to an even register number in the window produces exactly one single-cycle busWrEn. The pulse carries busWrData = {staged high half, frame data}.
- R6: A read frame to an even register number in the window produces exactly one single-cycle busRdEn at the frame's word address. It returns busRdData[15:0] on the line.
- R7: A read frame to an odd register number in the window issues no busRdEn. It returns busRdData[31:16] as captured by the most recent low-half read.
- R8: Frames to PHY addresses outside 0x10 to 0x17 and 0x1F never assert mdioOe and never produce a bus strobe.
- R9: In a claimed read frame, mdioOe rises for the second turnaround bit with mdioOut at 0. The 16 data bits follow MSB first, and mdioOe falls after the last data bit.
- R10: Frames with opcode 00 or 11 (read is 10, write is 01) are ignored: no drive and no strobe.
- R11: At PHY 0x1F, register numbers other than 0x10 read as 0, and writes to them leave the page register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples mdc |
| rstN | input | 1 | Active-low synchronous reset |
| mdc | input | 1 | Management clock from the master |
| mdioIn | input | 1 | Management data seen on the line |
| mdioOut | output | 1 | Management data driven by the bridge |
| mdioOe | output | 1 | Output enable for mdioOut |
| busAddr | output | 16 | Internal word address |
| busRdEn | output | 1 | Single-cycle internal read strobe |
| busRdData | input | 32 | Internal read data, valid while busRdEn is high |
| busWrEn | output | 1 | Single-cycle internal write strobe |
| busWrData | output | 32 | Internal write data |

## Verification
A page register that holds a wrong value shows up on busAddr at the very next bus strobe, and again whenever the page is read back over the line. A staging register that is corrupted or wrongly loaded only becomes visible one frame later, in the upper half of busWrData when the low-half write commits. A wrong read hold register is likewise seen only on the following high-half read. The bench therefore always pairs its half accesses and checks both frames. A header decode error, such as a misplaced claim window or a misread opcode, appears within the same frame: the bench sees an unexpected mdioOe, a missing or extra strobe, or a wrong address.

// File: rtl/mdio_page_bridge_pkg.sv
package mdio_page_bridge_pkg;
  localparam int HALF_W    = 16;
  localparam int PHY_W     = 5;
  localparam int REG_W     = 5;
  localparam int OP_W      = 2;
  localparam int HDR_BITS  = OP_W + PHY_W + REG_W;
  localparam int PHY_SEL_W = 3;
  localparam int REG_SEL_W = REG_W - 1;
  localparam int CNT_W     = $clog2(HALF_W) + 1;

  localparam logic [PHY_W-1:0] PAGE_PHY = 5'h1F;
  localparam logic [REG_W-1:0] PAGE_REG = 5'h10;
  localparam logic [PHY_W-PHY_SEL_W-1:0] WIN_TAG = 2'b10;
  localparam logic [OP_W-1:0] OP_READ  = 2'b10;
  localparam logic [OP_W-1:0] OP_WRITE = 2'b01;

  typedef struct packed {
    logic shiftIn;
    logic hdrDone;
    logic dataDone;
    logic taDrive;
    logic loadOut;
    logic shiftOut;
    logic dropDrive;
  } strobe_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_HDR,
    S_TURN,
    S_DATA
  } ctrl_state_t;
endpackage

// File: rtl/mdio_page_bridge_ctrl.sv
module mdio_page_bridge_ctrl
  import mdio_page_bridge_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    mdc,
  input  logic    mdioIn,
  input  logic    hdrClaim,
  input  logic    hdrRead,
  output strobe_t strobes,
  output logic    bitIn
);
  logic [SYNC_STAGES-1:0] mdcPipe;
  logic [SYNC_STAGES-1:0] mdioPipe;
  logic mdcLast;
  logic rise;
  ctrl_state_t state, nextState;
  logic [CNT_W-1:0] cnt, nextCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mdcPipe  <= '0;
      mdioPipe <= '1;
      mdcLast  <= 1'b0;
    end else begin
      mdcPipe  <= {mdcPipe[SYNC_STAGES-2:0], mdc};
      mdioPipe <= {mdioPipe[SYNC_STAGES-2:0], mdioIn};
      mdcLast  <= mdcPipe[SYNC_STAGES-1];
    end
  end

  assign rise  = mdcPipe[SYNC_STAGES-1] & ~mdcLast;
  assign bitIn = mdioPipe[SYNC_STAGES-1];

  always_comb begin
    strobes   = '0;
    nextState = state;
    nextCnt   = cnt;
    if (rise) begin
      unique case (state)
        S_IDLE: begin
          if (!bitIn) nextState = S_START;
        end
        S_START: begin
          nextCnt   = '0;
          nextState = bitIn ? S_HDR : S_IDLE;
        end
        S_HDR: begin
          strobes.shiftIn = 1'b1;
          if (cnt == CNT_W'(HDR_BITS - 1)) begin
            strobes.hdrDone = 1'b1;
            nextState = S_TURN;
            nextCnt   = '0;
          end else begin
            nextCnt = cnt + 1'b1;
          end
        end
        S_TURN: begin
          if (cnt == '0) begin
            strobes.taDrive = hdrClaim & hdrRead;
            nextCnt = CNT_W'(1);
          end else begin
            strobes.loadOut = hdrClaim & hdrRead;
            nextState = S_DATA;
            nextCnt   = '0;
          end
        end
        S_DATA: begin
          strobes.shiftIn = 1'b1;
          if (cnt == CNT_W'(HALF_W - 1)) begin
            strobes.dataDone  = 1'b1;
            strobes.dropDrive = 1'b1;
            nextState = S_IDLE;
            nextCnt   = '0;
          end else begin
            strobes.shiftOut = hdrClaim & hdrRead;
            nextCnt = cnt + 1'b1;
          end
        end
        default: nextState = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      state <= nextState;
      cnt   <= nextCnt;
    end
  end
endmodule

// File: rtl/mdio_page_bridge_dp.sv
module mdio_page_bridge_dp
  import mdio_page_bridge_pkg::*;
#(
  parameter int PAGE_W = 9,
  localparam int WORD_W = PAGE_W + PHY_SEL_W + REG_SEL_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strobes,
  input  logic                bitIn,
  output logic                hdrClaim,
  output logic                hdrRead,
  output logic                mdioOut,
  output logic                mdioOe,
  output logic [WORD_W-1:0]   busAddr,
  output logic                busRdEn,
  input  logic [2*HALF_W-1:0] busRdData,
  output logic                busWrEn,
  output logic [2*HALF_W-1:0] busWrData
);
  logic [HALF_W-1:0] inShift;
  logic [HALF_W-1:0] inNext;
  logic [OP_W-1:0]   opCode;
  logic [PHY_W-1:0]  phyNum;
  logic [REG_W-1:0]  regNum;
  logic isPage, isWin, opRd, opWr;

  logic [PAGE_W-1:0] pageQ;
  logic [HALF_W-1:0] stageQ;
  logic [HALF_W-1:0] loHold, hiHold;
  logic [HALF_W-1:0] outShift;
  logic [HALF_W-1:0] rdWord;
  logic [WORD_W-1:0] addrQ;
  logic claimQ, readQ, pageSelQ, pageRegQ, oddQ;
  logic rdEnQ, wrEnQ, oeQ;
  logic [2*HALF_W-1:0] wrDataQ;

  assign inNext = {inShift[HALF_W-2:0], bitIn};
  assign opCode = inNext[HDR_BITS-1 -: OP_W];
  assign phyNum = inNext[REG_W +: PHY_W];
  assign regNum = inNext[REG_W-1:0];
  assign isPage = (phyNum == PAGE_PHY);
  assign isWin  = (phyNum[PHY_W-1:PHY_SEL_W] == WIN_TAG);
  assign opRd   = (opCode == OP_READ);
  assign opWr   = (opCode == OP_WRITE);

  always_ff @(posedge clk) begin
    if (!rstN) inShift <= '0;
    else if (strobes.shiftIn) inShift <= inNext;
  end

  // header capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      claimQ   <= 1'b0;
      readQ    <= 1'b0;
      pageSelQ <= 1'b0;
      pageRegQ <= 1'b0;
      oddQ     <= 1'b0;
      addrQ    <= '0;
      rdEnQ    <= 1'b0;
    end else begin
      rdEnQ <= 1'b0;
      if (strobes.hdrDone) begin
        claimQ   <= (isPage | isWin) & (opRd | opWr);
        readQ    <= opRd;
        pageSelQ <= isPage;
        pageRegQ <= isPage && (regNum == PAGE_REG);
        oddQ     <= regNum[0];
        rdEnQ    <= isWin & opRd & ~regNum[0];
        if (isWin) addrQ <= {pageQ, phyNum[PHY_SEL_W-1:0], regNum[REG_W-1:1]};
      end
    end
  end

  // read hold: both halves sampled at the low-half bus read
  always_ff @(posedge clk) begin
    if (!rstN) begin
      loHold <= '0;
      hiHold <= '0;
    end else if (rdEnQ) begin
      loHold <= busRdData[HALF_W-1:0];
      hiHold <= busRdData[2*HALF_W-1:HALF_W];
    end
  end

  always_comb begin
    if (pageSelQ) rdWord = pageRegQ ? HALF_W'(pageQ) : '0;
    else          rdWord = oddQ ? hiHold : loHold;
  end

  // serial output
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outShift <= '0;
      oeQ      <= 1'b0;
    end else begin
      if (strobes.taDrive) begin
        outShift <= '0;
        oeQ      <= 1'b1;
      end else if (strobes.loadOut) begin
        outShift <= rdWord;
      end else if (strobes.shiftOut) begin
        outShift <= {outShift[HALF_W-2:0], 1'b0};
      end
      if (strobes.dropDrive) oeQ <= 1'b0;
    end
  end

  // write commit: staging for high half, full word on low half
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pageQ   <= '0;
      stageQ  <= '0;
      wrEnQ   <= 1'b0;
      wrDataQ <= '0;
    end else begin
      wrEnQ <= 1'b0;
      if (strobes.dataDone && claimQ && !readQ) begin
        if (pageSelQ) begin
          if (pageRegQ) pageQ <= inNext[PAGE_W-1:0];
        end else if (oddQ) begin
          stageQ <= inNext;
        end else begin
          wrEnQ   <= 1'b1;
          wrDataQ <= {stageQ, inNext};
        end
      end
    end
  end

  assign hdrClaim  = claimQ;
  assign hdrRead   = readQ;
  assign mdioOut   = outShift[HALF_W-1];
  assign mdioOe    = oeQ;
  assign busAddr   = addrQ;
  assign busRdEn   = rdEnQ;
  assign busWrEn   = wrEnQ;
  assign busWrData = wrDataQ;
endmodule

// File: rtl/mdio_page_bridge.sv
module mdio_page_bridge
  import mdio_page_bridge_pkg::*;
#(
  parameter int PAGE_W = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic                                      clk,
  input  logic                                      rstN,
  input  logic                                      mdc,
  input  logic                                      mdioIn,
  output logic                                      mdioOut,
  output logic                                      mdioOe,
  output logic [PAGE_W+PHY_SEL_W+REG_SEL_W-1:0]     busAddr,
  output logic                                      busRdEn,
  input  logic [2*HALF_W-1:0]                       busRdData,
  output logic                                      busWrEn,
  output logic [2*HALF_W-1:0]                       busWrData
);
  strobe_t strobes;
  logic bitIn;
  logic hdrClaim;
  logic hdrRead;

  mdio_page_bridge_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .mdc(mdc), .mdioIn(mdioIn),
    .hdrClaim(hdrClaim), .hdrRead(hdrRead),
    .strobes(strobes), .bitIn(bitIn)
  );

  mdio_page_bridge_dp #(.PAGE_W(PAGE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .bitIn(bitIn),
    .hdrClaim(hdrClaim), .hdrRead(hdrRead),
    .mdioOut(mdioOut), .mdioOe(mdioOe),
    .busAddr(busAddr), .busRdEn(busRdEn), .busRdData(busRdData),
    .busWrEn(busWrEn), .busWrData(busWrData)
  );
endmodule

// File: rtl/mdio_page_bridge_checker.sv
module mdio_page_bridge_checker (
  input logic clk,
  input logic rstN,
  input logic mdioOut,
  input logic mdioOe,
  input logic busRdEn,
  input logic busWrEn
);
  p_wr_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn |=> !busWrEn);

  p_rd_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    busRdEn |=> !busRdEn);

  p_rd_before_drive_r6: assert property (@(posedge clk) disable iff (!rstN)
    busRdEn |-> !mdioOe);

  p_wr_quiet_line_r4: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn |-> !mdioOe);

  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(busWrEn && busRdEn));

  p_ta_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mdioOe) |-> !mdioOut);
endmodule

bind mdio_page_bridge mdio_page_bridge_checker u_checker (
  .clk(clk), .rstN(rstN), .mdioOut(mdioOut), .mdioOe(mdioOe),
  .busRdEn(busRdEn), .busWrEn(busWrEn)
);

// File: tb/mdio_page_bridge_bench.sv
module mdio_page_bridge_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mdc = 1'b0;
  logic mdioIn = 1'b1;
  logic mdioOut, mdioOe, busRdEn, busWrEn;
  logic [15:0] busAddr;
  logic [31:0] busRdData, busWrData;

  int rdCount, wrCount, oeCycles;
  logic [15:0] lastRdAddr, lastWrAddr;
  logic [31:0] lastWrData;
  int testCount = 0;
  int failCount = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_page_bridge u_mdio_page_bridge (
    .clk(clk), .rstN(rstN), .mdc(mdc), .mdioIn(mdioIn),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .busAddr(busAddr),
    .busRdEn(busRdEn), .busRdData(busRdData),
    .busWrEn(busWrEn), .busWrData(busWrData)
  );

  // bus model: data depends on address and on how many reads came before
  assign busRdData = {busAddr ^ rdCount[15:0], busAddr + 16'h1234};

  always @(posedge clk) begin
    if (!rstN) begin
      rdCount <= 0; wrCount <= 0; oeCycles <= 0;
      lastRdAddr <= '0; lastWrAddr <= '0; lastWrData <= '0;
    end else begin
      if (busRdEn) begin rdCount <= rdCount + 1; lastRdAddr <= busAddr; end
      if (busWrEn) begin wrCount <= wrCount + 1; lastWrAddr <= busAddr; lastWrData <= busWrData; end
      if (mdioOe) oeCycles <= oeCycles + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic mdcBit(input logic b);
    mdioIn = b;
    repeat (HALF) @(negedge clk);
    mdc = 1'b1;
    repeat (HALF) @(negedge clk);
    mdc = 1'b0;
  endtask

  task automatic sampleBit(output logic o, output logic e);
    mdioIn = 1'b1;
    repeat (HALF) @(negedge clk);
    o = mdioOut; e = mdioOe;
    mdc = 1'b1;
    repeat (HALF) @(negedge clk);
    mdc = 1'b0;
  endtask

  task automatic sendBits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) mdcBit(v[i]);
  endtask

  task automatic sendHdr(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] rn);
    sendBits(32'h3F, 6);
    sendBits(32'b01, 2);
    sendBits({30'd0, op}, 2);
    sendBits({27'd0, phy}, 5);
    sendBits({27'd0, rn}, 5);
  endtask

  task automatic frameOut(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] rn, input logic [15:0] d);
    sendHdr(op, phy, rn);
    sendBits(32'b10, 2);
    sendBits({16'd0, d}, 16);
    sendBits(32'b11, 2);
  endtask

  task automatic mdioWrite(input logic [4:0] phy, input logic [4:0] rn, input logic [15:0] d);
    frameOut(2'b01, phy, rn, d);
  endtask

  task automatic mdioRead(input logic [4:0] phy, input logic [4:0] rn, output logic [15:0] d,
                          output bit taOk, output bit relOk);
    logic o, e;
    bit allOe;
    sendHdr(2'b10, phy, rn);
    mdcBit(1'b1);
    sampleBit(o, e);
    taOk = e && !o;
    allOe = 1'b1;
    for (int i = 15; i >= 0; i--) begin
      sampleBit(o, e);
      d[i] = o;
      allOe = allOe && e;
    end
    mdcBit(1'b1);
    relOk = allOe && !mdioOe;
  endtask

  function automatic logic [15:0] expAddr(input int page, input int phy, input int rn);
    return 16'((page % 512) * 128 + (phy % 8) * 16 + (rn / 2));
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    testCount++; failCount++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    logic [15:0] rd, hi, lo, ea;
    bit taOk, relOk;
    int c, w, oe0;
    int pages[2] = '{0, 511};
    int pvals[4] = '{16'h00A5, 16'h015A, 16'hFFFF, 16'h0000};

    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk(mdioOe == 1'b0, "R1 oe after reset", 32'(mdioOe), 0);
    chk(!busRdEn && !busWrEn, "R1 strobes after reset", 32'({busRdEn, busWrEn}), 0);
    mdioRead(5'h1F, 5'h10, rd, taOk, relOk);
    chk(rd == 16'h0, "R1 page reset value", 32'(rd), 0);

    // R2 page register
    foreach (pvals[i]) begin
      mdioWrite(5'h1F, 5'h10, 16'(pvals[i]));
      mdioRead(5'h1F, 5'h10, rd, taOk, relOk);
      chk(rd == 16'(pvals[i] & 16'h01FF), "R2 page readback", 32'(rd), 32'(pvals[i] & 16'h01FF));
      chk(taOk && relOk, "R9 page read drive", 32'({taOk, relOk}), 3);
    end

    // R11 other registers at the page PHY
    mdioWrite(5'h1F, 5'h10, 16'h0123);
    mdioWrite(5'h1F, 5'h11, 16'h0055);
    mdioRead(5'h1F, 5'h10, rd, taOk, relOk);
    chk(rd == 16'h0123, "R11 page unchanged", 32'(rd), 32'h0123);
    mdioRead(5'h1F, 5'h03, rd, taOk, relOk);
    chk(rd == 16'h0, "R11 other reg reads zero", 32'(rd), 0);

    // R3..R7, R9 sweep over pages, window PHYs and register pairs
    foreach (pages[pi]) begin
      mdioWrite(5'h1F, 5'h10, 16'(pages[pi]));
      for (int phy = 16; phy < 24; phy++) begin
        for (int k = 0; k < 2; k++) begin
          int rn;
          rn = (k == 0) ? 0 : 30;
          ea = expAddr(pages[pi], phy, rn);
          hi = 16'hA000 ^ 16'(pages[pi] * 97 + phy * 13 + rn);
          lo = 16'h5000 ^ 16'(phy * 211 + rn * 7 + pi);
          w = wrCount;
          mdioWrite(5'(phy), 5'(rn + 1), hi);
          chk(wrCount == w, "R4 high half no write", 32'(wrCount), 32'(w));
          mdioWrite(5'(phy), 5'(rn), lo);
          chk(wrCount == w + 1, "R5 one write", 32'(wrCount), 32'(w + 1));
          chk(lastWrAddr == ea, "R3 write address", 32'(lastWrAddr), 32'(ea));
          chk(lastWrData == {hi, lo}, "R5 write data", lastWrData, {hi, lo});
          c = rdCount;
          mdioRead(5'(phy), 5'(rn), rd, taOk, relOk);
          chk(rdCount == c + 1, "R6 one read", 32'(rdCount), 32'(c + 1));
          chk(lastRdAddr == ea, "R3 read address", 32'(lastRdAddr), 32'(ea));
          chk(rd == ea + 16'h1234, "R6 low half data", 32'(rd), 32'(ea + 16'h1234));
          chk(taOk && relOk, "R9 turnaround and release", 32'({taOk, relOk}), 3);
          mdioRead(5'(phy), 5'(rn + 1), rd, taOk, relOk);
          chk(rdCount == c + 1, "R7 no bus read", 32'(rdCount), 32'(c + 1));
          chk(rd == (ea ^ 16'(c)), "R7 high half held", 32'(rd), 32'(ea ^ 16'(c)));
        end
      end
    end

    // R3 register number sweep, low-half writes
    mdioWrite(5'h1F, 5'h10, 16'h0055);
    for (int rn = 0; rn < 32; rn += 2) begin
      ea = expAddr(16'h55, 16'h13, rn);
      mdioWrite(5'h13, 5'(rn), 16'(rn));
      chk(lastWrAddr == ea, "R3 regnum sweep address", 32'(lastWrAddr), 32'(ea));
    end

    // R8 unclaimed PHY addresses
    for (int phy = 0; phy < 32; phy++) begin
      if (!((phy >= 16 && phy < 24) || phy == 31)) begin
        c = rdCount; w = wrCount; oe0 = oeCycles;
        mdioRead(5'(phy), 5'h00, rd, taOk, relOk);
        mdioWrite(5'(phy), 5'h00, 16'hBEEF);
        chk(oeCycles == oe0, "R8 no drive", 32'(oeCycles), 32'(oe0));
        chk(rdCount == c && wrCount == w, "R8 no strobes", 32'(rdCount + wrCount), 32'(c + w));
      end
    end

    // R10 invalid opcodes
    for (int op = 0; op < 4; op += 3) begin
      c = rdCount; w = wrCount; oe0 = oeCycles;
      frameOut(2'(op), 5'h10, 5'h00, 16'h1111);
      chk(oeCycles == oe0, "R10 no drive", 32'(oeCycles), 32'(oe0));
      chk(rdCount == c && wrCount == w, "R10 no strobes", 32'(rdCount + wrCount), 32'(c + w));
    end

    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule